// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block owns the 64-bit register that places the memory-mapped PCIe configuration window in the physical address space. It turns that register into an enable, a window length and a masked base address. It then checks every incoming memory address against the window. On a match it raises a hit flag and splits the offset into bus, device, function and register fields for the logic that issues the configuration access.

The block also reports the lower and upper bounds of the 32-bit PCI memory hole. The hole starts where the window ends, or at the reset-default base while the window is off. It ends one byte below the fixed address of the interrupt controller. Software programs the register through a byte-enabled write port. A reserved size code does not stop the system: the block turns the window off and latches an error flag.

Top module: `cfgwin_decoder`

## Requirements
- R1: While reset is asserted and right after it, the register holds the default value 0xB0000000: window off, 256 MiB size code, base 0xB0000000, `holeStart` = 0xB0000000, `sizeErr` = 0, `cfgHit` = 0.
- R2: With the window on, `cfgHit` is 1 exactly when base <= `addr` < base + length. The result is combinational on `addr`.
- R3: Register bit 0 is the enable. While it is 0, `winEnabled` is 0 and no address hits.
- R4: Register bits [2:1] are the size code: 0 gives 256 MiB, 1 gives 128 MiB, 2 gives 64 MiB, and 3 is reserved.
- R5: The base always uses register bits [ADDR_W-1:28]. Size code 1 also uses bits 27 and 26. Size code 2 uses bit 26 as well but ignores bit 27.
- R6: `holeStart` equals base + length while the window is on, and the default base 0xB0000000 while it is off. `holeEnd` equals the interrupt controller address minus one (0xFEBFFFFF by default).
- R7: A write updates only the byte lanes whose `wrBe` bit is set (lane i = `wrData`[8i+7:8i]). All outputs show the new value from the cycle after the write edge. A write with no enabled lane changes nothing.
- R8: Writing size code 3 turns the window off and sets `sizeErr` from the next cycle. `sizeErr` stays set until reset, even after a valid size is written again, and a valid size turns the window back on.
- R9: On a hit, the offset from the base gives `cfgBus` = offset[27:20], `cfgDev` = offset[19:15], `cfgFunc` = offset[14:12] and `cfgReg` = offset[11:0]. Without a hit all four fields are 0.
- R10: A reset in the middle of operation reloads the default, clears `sizeErr` and recomputes every derived output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrBe | input | 8 | Byte-lane enables of the write |
| wrData | input | 64 | Write data |
| addr | input | ADDR_W | Memory address to decode |
| cfgHit | output | 1 | Address falls inside the configuration window |
| cfgBus | output | 8 | Decoded bus number |
| cfgDev | output | 5 | Decoded device number |
| cfgFunc | output | 3 | Decoded function number |
| cfgReg | output | 12 | Decoded register offset |
| winEnabled | output | 1 | Window is on and its size code is valid |
| holeStart | output | ADDR_W | First address of the 32-bit PCI hole |
| holeEnd | output | ADDR_W | Last address of the 32-bit PCI hole |
| sizeErr | output | 1 | Sticky flag: the reserved size code was written |

## Verification
The register and the error flag change at the write clock edge. Every other result, including the hit and the field split for a given `addr`, follows combinationally within that same cycle. The bench therefore drives its inputs 2 ns after a rising edge and compares all outputs at the next falling edge. It does this against a behavioural model that merges byte lanes at the rising edge, so each write is seen in the first cycle after its edge. Directed probes with hand-computed values cover the size codes, the mask bits, empty byte enables and the reserved code. The model also checks every cycle, including cycles spent in reset.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
package cfgwin_pkg;
  localparam int CFG_W     = 64;
  localparam int CFG_LANES = CFG_W / 8;
  localparam int ENABLE_BIT = 0;
  localparam int SIZE_LSB   = 1;
  localparam int BASE_LSB_256 = 28;

  typedef enum logic [1:0] {
    WIN_256M = 2'd0,
    WIN_128M = 2'd1,
    WIN_64M  = 2'd2,
    WIN_RSVD = 2'd3
  } winSize_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic [CFG_LANES-1:0] laneWr;
    logic                 flagResv;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfgwin_ctrl.sv
`timescale 1ns/1ps
module cfgwin_ctrl
  import cfgwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [CFG_LANES-1:0] wrBe,
  input  logic [1:0]           sizeCodeIn,
  output ctrlStrobe_t          strobe,
  output logic                 sizeErr
);
  logic resvWrite;

  // a reserved code can only arrive through lane 0
  assign resvWrite = wrEn && wrBe[0] && (winSize_e'(sizeCodeIn) == WIN_RSVD);

  always_comb begin
    strobe.laneWr   = wrEn ? wrBe : '0;
    strobe.flagResv = resvWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sizeErr <= 1'b0;
    else if (resvWrite) sizeErr <= 1'b1;
  end
endmodule

// File: rtl/cfgwin_match.sv
`timescale 1ns/1ps
module cfgwin_match #(
  parameter int ADDR_W = 36
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLen,
  input  logic              winOn,
  output logic              cfgHit,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFunc,
  output logic [11:0]       cfgReg
);
  logic [ADDR_W-1:0] offset;

  assign offset = addr - winBase;
  assign cfgHit = winOn && (addr >= winBase) && (offset < winLen);

  always_comb begin
    if (cfgHit) begin
      cfgBus  = offset[27:20];
      cfgDev  = offset[19:15];
      cfgFunc = offset[14:12];
      cfgReg  = offset[11:0];
    end else begin
      cfgBus  = '0;
      cfgDev  = '0;
      cfgFunc = '0;
      cfgReg  = '0;
    end
  end
endmodule

// File: rtl/cfgwin_dp.sv
`timescale 1ns/1ps
module cfgwin_dp
  import cfgwin_pkg::*;
#(
  parameter int                ADDR_W      = 36,
  parameter logic [CFG_W-1:0]  DEF_CFG     = 64'h0000_0000_B000_0000,
  parameter logic [ADDR_W-1:0] IOAPIC_ADDR = ADDR_W'(32'hFEC0_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CFG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic              cfgHit,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFunc,
  output logic [11:0]       cfgReg,
  output logic              winEnabled,
  output logic [ADDR_W-1:0] holeStart,
  output logic [ADDR_W-1:0] holeEnd
);
  localparam logic [ADDR_W-1:0] MASK_256 = {ADDR_W{1'b1}} << BASE_LSB_256;
  localparam logic [ADDR_W-1:0] BIT_27   = ADDR_W'(1) << 27;
  localparam logic [ADDR_W-1:0] BIT_26   = ADDR_W'(1) << 26;
  localparam logic [ADDR_W-1:0] DEF_BASE = DEF_CFG[ADDR_W-1:0] & MASK_256;

  logic [7:0]        cfgLane [CFG_LANES];
  logic [CFG_W-1:0]  cfgQ;
  winSize_e          sizeCode;
  logic [ADDR_W-1:0] baseMask;
  logic [ADDR_W-1:0] winLen;
  logic [ADDR_W-1:0] winBase;
  logic              unusedCfgBits;

  for (genvar i = 0; i < CFG_LANES; i++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 cfgLane[i] <= DEF_CFG[8*i +: 8];
      else if (strobe.laneWr[i]) cfgLane[i] <= wrData[8*i +: 8];
    end
    assign cfgQ[8*i +: 8] = cfgLane[i];
  end

  assign unusedCfgBits = ^{cfgQ[CFG_W-1:ADDR_W], cfgQ[25:3], strobe.flagResv};

  assign sizeCode   = winSize_e'(cfgQ[SIZE_LSB +: 2]);
  assign winEnabled = cfgQ[ENABLE_BIT] && (sizeCode != WIN_RSVD);

  always_comb begin
    unique case (sizeCode)
      WIN_128M: begin
        baseMask = MASK_256 | BIT_27 | BIT_26;
        winLen   = ADDR_W'(1) << 27;
      end
      WIN_64M: begin
        baseMask = MASK_256 | BIT_26;
        winLen   = ADDR_W'(1) << 26;
      end
      default: begin
        baseMask = MASK_256;
        winLen   = ADDR_W'(1) << 28;
      end
    endcase
  end

  assign winBase   = cfgQ[ADDR_W-1:0] & baseMask;
  assign holeStart = winEnabled ? (winBase + winLen) : DEF_BASE;
  assign holeEnd   = IOAPIC_ADDR - ADDR_W'(1);

  cfgwin_match #(.ADDR_W(ADDR_W)) uMatch (
    .addr    (addr),
    .winBase (winBase),
    .winLen  (winLen),
    .winOn   (winEnabled),
    .cfgHit  (cfgHit),
    .cfgBus  (cfgBus),
    .cfgDev  (cfgDev),
    .cfgFunc (cfgFunc),
    .cfgReg  (cfgReg)
  );
endmodule

// File: rtl/cfgwin_decoder.sv
`timescale 1ns/1ps
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int                ADDR_W      = 36,
  parameter logic [63:0]       DEF_CFG     = 64'h0000_0000_B000_0000,
  parameter logic [ADDR_W-1:0] IOAPIC_ADDR = ADDR_W'(32'hFEC0_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrBe,
  input  logic [63:0]       wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic              cfgHit,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFunc,
  output logic [11:0]       cfgReg,
  output logic              winEnabled,
  output logic [ADDR_W-1:0] holeStart,
  output logic [ADDR_W-1:0] holeEnd,
  output logic              sizeErr
);
  ctrlStrobe_t strobe;

  cfgwin_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrBe       (wrBe),
    .sizeCodeIn (wrData[SIZE_LSB +: 2]),
    .strobe     (strobe),
    .sizeErr    (sizeErr)
  );

  cfgwin_dp #(
    .ADDR_W      (ADDR_W),
    .DEF_CFG     (DEF_CFG),
    .IOAPIC_ADDR (IOAPIC_ADDR)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .addr       (addr),
    .cfgHit     (cfgHit),
    .cfgBus     (cfgBus),
    .cfgDev     (cfgDev),
    .cfgFunc    (cfgFunc),
    .cfgReg     (cfgReg),
    .winEnabled (winEnabled),
    .holeStart  (holeStart),
    .holeEnd    (holeEnd)
  );
endmodule

module cfgwin_chk #(
  parameter int          ADDR_W  = 36,
  parameter logic [63:0] DEF_CFG = 64'h0000_0000_B000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [7:0]        wrBe,
  input logic [63:0]       wrData,
  input logic [ADDR_W-1:0] addr,
  input logic              cfgHit,
  input logic [7:0]        cfgBus,
  input logic [4:0]        cfgDev,
  input logic [2:0]        cfgFunc,
  input logic [11:0]       cfgReg,
  input logic              winEnabled,
  input logic [ADDR_W-1:0] holeStart,
  input logic              sizeErr
);
  localparam logic [ADDR_W-1:0] DEF_BASE = DEF_CFG[ADDR_W-1:0] & ({ADDR_W{1'b1}} << 28);

  a_r3_no_hit_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !winEnabled |-> !cfgHit);

  a_r2_hit_below_hole: assert property (@(posedge clk) disable iff (!rstN)
    cfgHit |-> (addr < holeStart));

  a_r6_hole_default_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !winEnabled |-> (holeStart == DEF_BASE));

  a_r9_fields_zero_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    !cfgHit |-> (cfgBus == 8'd0 && cfgDev == 5'd0 && cfgFunc == 3'd0 && cfgReg == 12'd0));

  a_r8_resv_disables: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrBe[0] && wrData[2:1] == 2'b11) |=> (sizeErr && !winEnabled));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    sizeErr |=> sizeErr);

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(winEnabled) && $stable(holeStart) && $stable(sizeErr)));
endmodule

bind cfgwin_decoder cfgwin_chk #(.ADDR_W(ADDR_W), .DEF_CFG(DEF_CFG)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrBe       (wrBe),
  .wrData     (wrData),
  .addr       (addr),
  .cfgHit     (cfgHit),
  .cfgBus     (cfgBus),
  .cfgDev     (cfgDev),
  .cfgFunc    (cfgFunc),
  .cfgReg     (cfgReg),
  .winEnabled (winEnabled),
  .holeStart  (holeStart),
  .sizeErr    (sizeErr)
);

// File: tb/cfgwin_decoder_test.sv
`timescale 1ns/1ps
module cfgwin_decoder_test;
  localparam int          AW     = 36;
  localparam logic [63:0] DEF    = 64'h0000_0000_B000_0000;
  localparam logic [63:0] AMASK  = (64'd1 << AW) - 64'd1;
  localparam logic [63:0] DEFB   = 64'hB000_0000;
  localparam logic [63:0] HEND   = 64'hFEBF_FFFF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [7:0]    wrBe = '0;
  logic [63:0]   wrData = '0;
  logic [AW-1:0] addr = '0;
  logic          cfgHit, winEnabled, sizeErr;
  logic [7:0]    cfgBus;
  logic [4:0]    cfgDev;
  logic [2:0]    cfgFunc;
  logic [11:0]   cfgReg;
  logic [AW-1:0] holeStart, holeEnd;

  int nRun = 0;
  int nFail = 0;
  logic [63:0] mCfg;
  logic        mErr;

  always #5 clk = ~clk;

  cfgwin_decoder uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .wrData(wrData),
    .addr(addr), .cfgHit(cfgHit), .cfgBus(cfgBus), .cfgDev(cfgDev),
    .cfgFunc(cfgFunc), .cfgReg(cfgReg), .winEnabled(winEnabled),
    .holeStart(holeStart), .holeEnd(holeEnd), .sizeErr(sizeErr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference: register image updated at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCfg = DEF;
      mErr = 1'b0;
    end else if (wrEn) begin
      for (int i = 0; i < 8; i++)
        if (wrBe[i]) mCfg[8*i +: 8] = wrData[8*i +: 8];
      if (wrBe[0] && wrData[2:1] == 2'b11) mErr = 1'b1;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    int sz;
    logic en, hit;
    logic [63:0] len, base, off, a;
    sz   = int'(mCfg[2:1]);
    en   = mCfg[0] && sz != 3;
    len  = 64'd1 << (28 - ((sz == 3) ? 0 : sz));
    base = mCfg & AMASK & ~((64'd1 << 28) - 64'd1);
    if (sz == 1) base = base | (mCfg & 64'h0C00_0000);
    if (sz == 2) base = base | (mCfg & 64'h0400_0000);
    a    = {28'd0, addr};
    hit  = en && a >= base && a < base + len;
    off  = a - base;
    chk("R2 model hit", {63'd0, cfgHit}, {63'd0, hit});
    chk("R9 model bus", {56'd0, cfgBus}, hit ? {56'd0, off[27:20]} : 64'd0);
    chk("R9 model dev", {59'd0, cfgDev}, hit ? {59'd0, off[19:15]} : 64'd0);
    chk("R9 model func", {61'd0, cfgFunc}, hit ? {61'd0, off[14:12]} : 64'd0);
    chk("R9 model reg", {52'd0, cfgReg}, hit ? {52'd0, off[11:0]} : 64'd0);
    chk("R3 model enable", {63'd0, winEnabled}, {63'd0, en});
    chk("R6 model hole start", {28'd0, holeStart}, en ? ((base + len) & AMASK) : DEFB);
    chk("R6 model hole end", {28'd0, holeEnd}, HEND);
    chk("R8 model error flag", {63'd0, sizeErr}, {63'd0, mErr});
  end

  task automatic wr(logic [7:0] be, logic [63:0] d);
    @(posedge clk); #2;
    wrEn = 1'b1; wrBe = be; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0; wrBe = '0; wrData = '0;
  endtask

  task automatic probe(logic [63:0] a);
    @(posedge clk); #2;
    addr = a[AW-1:0];
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    addr = 36'hB_0000_0000 >> 4;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 reset enable", {63'd0, winEnabled}, 64'd0);
    chk("R1 reset hole", {28'd0, holeStart}, DEFB);
    chk("R1 reset err", {63'd0, sizeErr}, 64'd0);
    chk("R1 reset hit", {63'd0, cfgHit}, 64'd0);
    @(posedge clk); #2; rstN = 1'b1;

    // R3: default window is off
    probe(64'hB000_0000);
    chk("R3 off no hit", {63'd0, cfgHit}, 64'd0);

    // R2/R4: 256 MiB at 0xB0000000
    wr(8'h01, 64'h1);
    probe(64'hBFFF_FFFF);
    chk("R2 last byte hit", {63'd0, cfgHit}, 64'd1);
    probe(64'hC000_0000);
    chk("R2 past end miss", {63'd0, cfgHit}, 64'd0);
    probe(64'hAFFF_FFFF);
    chk("R2 below base miss", {63'd0, cfgHit}, 64'd0);
    chk("R6 hole 256M", {28'd0, holeStart}, 64'hC000_0000);

    // R9: field split
    probe(64'hB051_A07C);
    chk("R9 bus", {56'd0, cfgBus}, 64'd5);
    chk("R9 dev", {59'd0, cfgDev}, 64'd3);
    chk("R9 func", {61'd0, cfgFunc}, 64'd2);
    chk("R9 reg", {52'd0, cfgReg}, 64'h7C);

    // R4: 128 MiB
    wr(8'h01, 64'h3);
    probe(64'hB7FF_FFFF);
    chk("R4 128M inside", {63'd0, cfgHit}, 64'd1);
    probe(64'hB800_0000);
    chk("R4 128M end miss", {63'd0, cfgHit}, 64'd0);

    // R5: bits 27 and 26 count at 128 MiB
    wr(8'h08, 64'hBC00_0000);
    chk("R5 128M base bits", {28'd0, holeStart}, 64'hC400_0000);
    probe(64'hBC00_0000);
    chk("R5 128M new base hit", {63'd0, cfgHit}, 64'd1);
    probe(64'hBBFF_FFFF);
    chk("R5 128M below miss", {63'd0, cfgHit}, 64'd0);

    // R5: 64 MiB ignores bit 27, keeps bit 26
    wr(8'h01, 64'h5);
    chk("R5 64M hole", {28'd0, holeStart}, 64'hB800_0000);
    probe(64'hB400_0000);
    chk("R5 64M base hit", {63'd0, cfgHit}, 64'd1);
    probe(64'hBC00_0000);
    chk("R4 64M outside", {63'd0, cfgHit}, 64'd0);

    // R7: empty byte enables change nothing
    wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7 no lanes hole", {28'd0, holeStart}, 64'hB800_0000);
    chk("R7 no lanes enable", {63'd0, winEnabled}, 64'd1);
    chk("R7 no lanes err", {63'd0, sizeErr}, 64'd0);

    // R7: upper lane only
    wr(8'h10, 64'h0000_0001_0000_0000);
    chk("R7 upper lane hole", {28'd0, holeStart}, 64'h1_B800_0000);
    probe(64'h1_B400_0000);
    chk("R7 upper lane hit", {63'd0, cfgHit}, 64'd1);

    // R8: reserved size code
    wr(8'h01, 64'h7);
    chk("R8 resv off", {63'd0, winEnabled}, 64'd0);
    chk("R8 resv err", {63'd0, sizeErr}, 64'd1);
    chk("R8 resv hole", {28'd0, holeStart}, DEFB);
    wr(8'h01, 64'h1);
    chk("R8 recovered enable", {63'd0, winEnabled}, 64'd1);
    chk("R8 err sticky", {63'd0, sizeErr}, 64'd1);
    chk("R8 recovered hole", {28'd0, holeStart}, 64'h1_C000_0000);

    // R3: clear enable
    wr(8'h01, 64'h0);
    probe(64'h1_B000_0000);
    chk("R3 cleared no hit", {63'd0, cfgHit}, 64'd0);
    chk("R3 cleared hole", {28'd0, holeStart}, DEFB);

    // R10: reset mid-run
    wr(8'h01, 64'h1);
    @(posedge clk); #2; rstN = 1'b0;
    @(negedge clk);
    chk("R10 reset err", {63'd0, sizeErr}, 64'd0);
    chk("R10 reset enable", {63'd0, winEnabled}, 64'd0);
    @(posedge clk); #2; rstN = 1'b1;
    @(negedge clk);
    chk("R10 after reset hole", {28'd0, holeStart}, DEFB);
    wr(8'h01, 64'h1);
    chk("R10 default base back", {28'd0, holeStart}, 64'hC000_0000);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule